// File: doc/BRIEF.md
# Pending Interrupt Priority Selector

This block chooses which pending interrupt a processor core takes next. Each cycle it looks at eight request lines, one per interrupt class. Three are non-maskable classes (physical, virtual, virtual fast), and the other five are physical FIQ, physical IRQ, virtual IRQ, virtual FIQ and virtual SError. An external unmask evaluator supplies one unmask bit per class. The selector walks the classes in a fixed priority order and picks the first one that is both pending and unmasked. It then presents a registered take strobe together with the class code and the target exception level.

The non-maskable group is honoured only while `nmiEn` is high. While `nmiEn` is low, each of those requests is treated as a request of its ordinary counterpart. Physical classes take their target level from per-class inputs. Every virtual class targets level 1. Taking a virtual SError raises a one-cycle clear pulse for the hypervisor's enable bit. The selector also stops treating that request as pending until the line is seen low.

Top module: `irq_take_sel`

## Requirements
- R1: After reset, `takeValid`, `takeClass`, `takeLevel` and `vseClear` are all zero.
- R2: The class code equals the request bit index: 0 NMI, 1 virtual NMI, 2 virtual fast NMI, 3 FIQ, 4 IRQ, 5 virtual IRQ, 6 virtual FIQ, 7 virtual SError. With `nmiEn` high, the lowest-numbered class that is pending and unmasked is taken.
- R3: A class that is pending but masked is skipped, and the next lower-priority qualifying class is taken.
- R4: With `nmiEn` low, the three non-maskable requests are folded into their ordinary counterparts and are never reported themselves. Physical NMI folds into IRQ (class 4), virtual NMI into virtual IRQ (class 5), and virtual fast NMI into virtual FIQ (class 6). A folded request uses the unmask bit and target level of the class it joins.
- R5: Physical NMI reports `tgtNmi`, FIQ reports `tgtFiq` and IRQ reports `tgtIrq`, each as sampled with the requests.
- R6: Classes 1, 2, 5, 6 and 7 always report target level 1.
- R7: The outputs register the selection made from the inputs at the previous clock edge, and each selection is valid for one cycle.
- R8: `vseClear` pulses in exactly the cycles in which class 7 is reported taken.
- R9: Once class 7 has been taken, request bit 7 is ignored until it has been sampled low at a clock edge. During that time lower classes cannot exist, so nothing is taken for it.
- R10: When no class qualifies, `takeValid` is low and `takeClass` and `takeLevel` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| nmiEn | input | 1 | Non-maskable interrupt support enabled at the current level |
| pendReq | input | 8 | Pending request per class, bit index = class code |
| unmaskReq | input | 8 | Unmask verdict per class from the external evaluator |
| tgtNmi | input | LVL_W | Target level for physical NMI |
| tgtFiq | input | LVL_W | Target level for physical FIQ |
| tgtIrq | input | LVL_W | Target level for physical IRQ |
| takeValid | output | 1 | A class was taken this cycle |
| takeClass | output | 3 | Code of the taken class |
| takeLevel | output | LVL_W | Target exception level of the taken class |
| vseClear | output | 1 | Clear pulse for the virtual SError enable bit |

## Verification
The bench builds the block with the default two-bit level width and a virtual target of 1. This keeps all four physical level values available, so each physical target input can be told apart from the others and from the fixed virtual level. The per-class targets are also changed part way through the run, so that a level held over from an earlier cycle would show as a mismatch. Toggling `nmiEn` under random request and unmask patterns brings both folding and suppression of the virtual SError within reach.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;

  localparam int NUM_CLS = 8;
  localparam int CLS_W   = $clog2(NUM_CLS);

  typedef enum logic [CLS_W-1:0] {
    CLS_NMI   = 3'd0,
    CLS_VNMI  = 3'd1,
    CLS_VFNMI = 3'd2,
    CLS_FIQ   = 3'd3,
    CLS_IRQ   = 3'd4,
    CLS_VIRQ  = 3'd5,
    CLS_VFIQ  = 3'd6,
    CLS_VSERR = 3'd7
  } irqCls_e;

  // number of non-maskable classes and the distance to their ordinary partner
  localparam int FOLD_N     = 3;
  localparam int FOLD_SHIFT = int'(CLS_IRQ) - int'(CLS_NMI);

  typedef struct packed {
    logic               take;
    logic [NUM_CLS-1:0] grant;
    logic               vsTake;
  } selStrobe_t;

endpackage

// File: rtl/irqsel_ctrl.sv
module irqsel_ctrl
  import irqsel_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_CLS-1:0] cand,
  input  logic               pendVs,
  output selStrobe_t         stb,
  output logic               vsSupp
);

  logic [NUM_CLS:0]   seen;
  logic [NUM_CLS-1:0] grantVec;

  assign seen[0] = 1'b0;

  // priority chain: lowest class index wins
  for (genvar g = 0; g < NUM_CLS; g++) begin : g_prio
    assign grantVec[g] = cand[g] & ~seen[g];
    assign seen[g+1]   = seen[g] | cand[g];
  end

  always_comb begin
    stb.take   = seen[NUM_CLS];
    stb.grant  = grantVec;
    stb.vsTake = grantVec[int'(CLS_VSERR)];
  end

  // hold off a taken virtual SError until its line is seen low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vsSupp <= 1'b0;
    end else if (stb.vsTake) begin
      vsSupp <= 1'b1;
    end else if (!pendVs) begin
      vsSupp <= 1'b0;
    end
  end

endmodule

// File: rtl/irqsel_dp.sv
module irqsel_dp
  import irqsel_pkg::*;
#(
  parameter int LVL_W    = 2,
  parameter int VIRT_LVL = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               nmiEn,
  input  logic [NUM_CLS-1:0] pendReq,
  input  logic [NUM_CLS-1:0] unmaskReq,
  input  logic               vsSupp,
  input  logic [LVL_W-1:0]   tgtNmi,
  input  logic [LVL_W-1:0]   tgtFiq,
  input  logic [LVL_W-1:0]   tgtIrq,
  input  selStrobe_t         stb,
  output logic [NUM_CLS-1:0] cand,
  output logic               takeValid,
  output logic [CLS_W-1:0]   takeClass,
  output logic [LVL_W-1:0]   takeLevel,
  output logic               vseClear
);

  localparam logic [LVL_W-1:0] VIRT_L = LVL_W'(VIRT_LVL);

  logic [NUM_CLS-1:0] effPend;
  logic [LVL_W-1:0]   laneLvl [NUM_CLS];
  logic [CLS_W-1:0]   encCls;
  logic [LVL_W-1:0]   lvlNext;

  // request folding and virtual SError hold-off
  for (genvar g = 0; g < NUM_CLS; g++) begin : g_fold
    if (g < FOLD_N) begin : g_nmi
      assign effPend[g] = nmiEn & pendReq[g];
    end else if (g >= FOLD_SHIFT && g < FOLD_SHIFT + FOLD_N) begin : g_join
      assign effPend[g] = pendReq[g] | (~nmiEn & pendReq[g-FOLD_SHIFT]);
    end else if (g == int'(CLS_VSERR)) begin : g_vs
      assign effPend[g] = pendReq[g] & ~vsSupp;
    end else begin : g_plain
      assign effPend[g] = pendReq[g];
    end
  end

  assign cand = effPend & unmaskReq;

  // per-class target level lanes
  for (genvar g = 0; g < NUM_CLS; g++) begin : g_lvl
    if (g == int'(CLS_NMI)) begin : g_pn
      assign laneLvl[g] = tgtNmi;
    end else if (g == int'(CLS_FIQ)) begin : g_pf
      assign laneLvl[g] = tgtFiq;
    end else if (g == int'(CLS_IRQ)) begin : g_pi
      assign laneLvl[g] = tgtIrq;
    end else begin : g_virt
      assign laneLvl[g] = VIRT_L;
    end
  end

  // one-hot grant to code and level (and-or, zero when idle)
  always_comb begin
    encCls  = '0;
    lvlNext = '0;
    for (int i = 0; i < NUM_CLS; i++) begin
      if (stb.grant[i]) begin
        encCls  = encCls | CLS_W'(i);
        lvlNext = lvlNext | laneLvl[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      takeValid <= 1'b0;
      takeClass <= '0;
      takeLevel <= '0;
      vseClear  <= 1'b0;
    end else begin
      takeValid <= stb.take;
      takeClass <= encCls;
      takeLevel <= lvlNext;
      vseClear  <= stb.vsTake;
    end
  end

endmodule

// File: rtl/irq_take_sel.sv
module irq_take_sel
  import irqsel_pkg::*;
#(
  parameter int LVL_W    = 2,
  parameter int VIRT_LVL = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               nmiEn,
  input  logic [NUM_CLS-1:0] pendReq,
  input  logic [NUM_CLS-1:0] unmaskReq,
  input  logic [LVL_W-1:0]   tgtNmi,
  input  logic [LVL_W-1:0]   tgtFiq,
  input  logic [LVL_W-1:0]   tgtIrq,
  output logic               takeValid,
  output logic [CLS_W-1:0]   takeClass,
  output logic [LVL_W-1:0]   takeLevel,
  output logic               vseClear
);

  selStrobe_t         stb;
  logic [NUM_CLS-1:0] cand;
  logic               vsSupp;

  irqsel_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .cand   (cand),
    .pendVs (pendReq[int'(CLS_VSERR)]),
    .stb    (stb),
    .vsSupp (vsSupp)
  );

  irqsel_dp #(
    .LVL_W    (LVL_W),
    .VIRT_LVL (VIRT_LVL)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .nmiEn     (nmiEn),
    .pendReq   (pendReq),
    .unmaskReq (unmaskReq),
    .vsSupp    (vsSupp),
    .tgtNmi    (tgtNmi),
    .tgtFiq    (tgtFiq),
    .tgtIrq    (tgtIrq),
    .stb       (stb),
    .cand      (cand),
    .takeValid (takeValid),
    .takeClass (takeClass),
    .takeLevel (takeLevel),
    .vseClear  (vseClear)
  );

endmodule

// File: rtl/irq_take_sel_chk.sv
module irq_take_sel_chk
  import irqsel_pkg::*;
#(
  parameter int LVL_W    = 2,
  parameter int VIRT_LVL = 1
) (
  input logic               clk,
  input logic               rstN,
  input logic               nmiEn,
  input logic [NUM_CLS-1:0] pendReq,
  input logic [NUM_CLS-1:0] unmaskReq,
  input logic [LVL_W-1:0]   tgtIrq,
  input logic               takeValid,
  input logic [CLS_W-1:0]   takeClass,
  input logic [LVL_W-1:0]   takeLevel,
  input logic               vseClear
);

  localparam logic [LVL_W-1:0] VIRT_L = LVL_W'(VIRT_LVL);

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    !takeValid |-> (takeClass == '0 && takeLevel == '0));

  p_clear_needs_take_r8: assert property (@(posedge clk) disable iff (!rstN)
    vseClear |-> (takeValid && takeClass == CLS_VSERR));

  p_take_gives_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (takeValid && takeClass == CLS_VSERR) |-> vseClear);

  p_virt_level_r6: assert property (@(posedge clk) disable iff (!rstN)
    (takeValid && (takeClass == CLS_VNMI || takeClass == CLS_VFNMI ||
                   takeClass == CLS_VIRQ || takeClass == CLS_VFIQ ||
                   takeClass == CLS_VSERR)) |-> takeLevel == VIRT_L);

  p_fold_hides_nmi_r4: assert property (@(posedge clk) disable iff (!rstN)
    (takeValid && !$past(nmiEn)) |-> takeClass >= CLS_FIQ);

  p_irq_level_r5: assert property (@(posedge clk) disable iff (!rstN)
    (takeValid && takeClass == CLS_IRQ) |-> takeLevel == $past(tgtIrq));

  p_take_has_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    takeValid |-> ($past(|pendReq) && $past(|unmaskReq)));

  p_nmi_first_r2: assert property (@(posedge clk) disable iff (!rstN)
    (takeValid && takeClass != CLS_NMI && $past(nmiEn))
      |-> !($past(pendReq[0]) && $past(unmaskReq[0])));

  p_vserr_once_r9: assert property (@(posedge clk) disable iff (!rstN)
    vseClear |=> !vseClear);

endmodule

bind irq_take_sel irq_take_sel_chk #(
  .LVL_W    (LVL_W),
  .VIRT_LVL (VIRT_LVL)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .nmiEn     (nmiEn),
  .pendReq   (pendReq),
  .unmaskReq (unmaskReq),
  .tgtIrq    (tgtIrq),
  .takeValid (takeValid),
  .takeClass (takeClass),
  .takeLevel (takeLevel),
  .vseClear  (vseClear)
);

// File: tb/irq_take_sel_tb.sv
module irq_take_sel_tb_top;

  localparam int LVL_W = 2;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             nmiEn = 1'b0;
  logic [7:0]       pendReq = '0;
  logic [7:0]       unmaskReq = '0;
  logic [LVL_W-1:0] tgtNmi = 2'd3;
  logic [LVL_W-1:0] tgtFiq = 2'd2;
  logic [LVL_W-1:0] tgtIrq = 2'd0;
  logic             takeValid;
  logic [2:0]       takeClass;
  logic [LVL_W-1:0] takeLevel;
  logic             vseClear;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  bit mdlSupp = 0;

  always #5 clk = ~clk;

  irq_take_sel #(.LVL_W(LVL_W), .VIRT_LVL(1)) dut_i (
    .clk(clk), .rstN(rstN), .nmiEn(nmiEn), .pendReq(pendReq),
    .unmaskReq(unmaskReq), .tgtNmi(tgtNmi), .tgtFiq(tgtFiq), .tgtIrq(tgtIrq),
    .takeValid(takeValid), .takeClass(takeClass), .takeLevel(takeLevel),
    .vseClear(vseClear)
  );

  task automatic chk(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // one clock: apply at negedge, model the edge, compare at the next negedge
  task automatic cyc(bit nmi, bit [7:0] p, bit [7:0] u, string tag);
    int order[$];
    bit [7:0] eff;
    int expCls;
    int expLvl;
    bit expValid;
    nmiEn = nmi; pendReq = p; unmaskReq = u;
    eff = p;
    if (!nmi) begin
      if (p[0]) eff[4] = 1;   // NMI joins IRQ
      if (p[1]) eff[5] = 1;   // virtual NMI joins virtual IRQ
      if (p[2]) eff[6] = 1;   // virtual fast NMI joins virtual FIQ
      eff[0] = 0; eff[1] = 0; eff[2] = 0;
    end
    if (mdlSupp) eff[7] = 0;
    order = '{0, 1, 2, 3, 4, 5, 6, 7};
    expValid = 0; expCls = 0; expLvl = 0;
    foreach (order[k]) begin
      if (!expValid && eff[order[k]] && u[order[k]]) begin
        expValid = 1;
        expCls = order[k];
      end
    end
    if (expValid) begin
      case (expCls)
        0: expLvl = int'(tgtNmi);
        3: expLvl = int'(tgtFiq);
        4: expLvl = int'(tgtIrq);
        default: expLvl = 1;
      endcase
    end
    if (expValid && expCls == 7) mdlSupp = 1;
    else if (!p[7]) mdlSupp = 0;
    @(negedge clk);
    chk(tag, "takeValid (R7)", int'(takeValid), int'(expValid));
    chk(tag, "takeClass", int'(takeClass), expCls);
    chk((expCls == 0 || expCls == 3 || expCls == 4) ? "R5" : "R6",
        "takeLevel", int'(takeLevel), expLvl);
    chk("R8", "vseClear", int'(vseClear), int'(expValid && expCls == 7));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "takeValid", int'(takeValid), 0);
    chk("R1", "takeClass", int'(takeClass), 0);
    chk("R1", "takeLevel", int'(takeLevel), 0);
    chk("R1", "vseClear", int'(vseClear), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "takeValid after release", int'(takeValid), 0);

    // R2 priority, R3 masking walk, R5/R6 levels
    cyc(1, 8'hFF, 8'hFF, "R2");
    cyc(1, 8'hFF, 8'hFE, "R3");
    cyc(1, 8'hFF, 8'hFC, "R3");
    cyc(1, 8'hFF, 8'hF8, "R5");
    cyc(1, 8'hFF, 8'hF0, "R5");
    cyc(1, 8'hFF, 8'hE0, "R6");
    cyc(1, 8'hFF, 8'hC0, "R6");
    // R8 take of virtual SError, then R9 hold-off while the line stays high
    cyc(1, 8'hFF, 8'h80, "R8");
    cyc(1, 8'hFF, 8'h80, "R9");
    cyc(1, 8'h80, 8'h80, "R9");
    cyc(1, 8'h00, 8'h80, "R9");
    cyc(1, 8'h80, 8'h80, "R9");
    cyc(1, 8'h80, 8'h80, "R9");

    // R4 folding with NMI support off
    cyc(0, 8'h01, 8'h10, "R4");
    cyc(0, 8'h01, 8'h01, "R4");
    cyc(0, 8'h02, 8'h20, "R4");
    cyc(0, 8'h04, 8'h40, "R4");
    cyc(0, 8'h07, 8'hFF, "R4");
    cyc(0, 8'h09, 8'h18, "R4");

    // R10 nothing qualifies
    cyc(1, 8'h00, 8'hFF, "R10");
    cyc(1, 8'hFF, 8'h00, "R10");
    cyc(1, 8'h55, 8'hAA, "R10");

    // R7 back-to-back selections follow the inputs one cycle later
    cyc(1, 8'h10, 8'hFF, "R7");
    cyc(1, 8'h08, 8'hFF, "R7");
    cyc(1, 8'h01, 8'hFF, "R7");

    // random patterns, targets changed part way
    for (int k = 0; k < 400; k++) begin
      if (k == 200) begin
        tgtNmi = 2'd1; tgtFiq = 2'd3; tgtIrq = 2'd2;
      end
      cyc(bit'($urandom_range(0, 1)), 8'($urandom), 8'($urandom), "R2");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule